// File: doc/BRIEF.md
# Processor trap entry sequencer

This block carries out the state change a windowed-register integer unit makes when it accepts a trap. When a trap request arrives it takes the current program counter, next program counter, current window pointer, supervisor bit, trap-enable bit and trap base address. On the following clock edge it presents the complete set of new values. The new values are the trap-vector PC, the next PC, the rotated window pointer, the previous-supervisor bit, the supervisor bit, a cleared trap-enable bit and the updated trap base register. In the same cycle it presents two register-file write requests, an interrupt acknowledge and a commit strobe.

A trap that arrives while traps are disabled is not taken. The block enters a sticky error state instead and stays there until reset. There is one exception: if the optional shutdown feature is on and the trap number is 0x80, the block pulses a shutdown request and does not enter error state. The register file, the fetch path and the interrupt controller lie outside the block. They consume the registered outputs.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset, every output is 0, including `errorState`, `commitValid`, `saveEn`, `ackValid` and `shutdownReq`.
- R2: Suppose `trapReq` is sampled high with `curEt` = 0, and the shutdown case of R3 does not apply. Then no commit happens, and `errorState` reads 1 from the next cycle on.
- R3: Suppose `trapReq` is sampled high with `curEt` = 0, `trapType` = 0x80 and `shutdownEn` = 1. Then `shutdownReq` is 1 for exactly one cycle after that edge, `errorState` stays 0 and no commit happens.
- R4: Suppose `trapReq` is sampled high with `curEt` = 1 outside error state. Then `commitValid` and `saveEn` are 1 for exactly the one cycle after that edge, and `newEt` is 0.
- R5: On a commit, `newCwp` and `saveCwp` equal `curCwp` minus 1, modulo NWIN. With 8 windows, 0 becomes 7.
- R6: On a commit, `saveDataPc` carries the old PC and `saveIdxPc` = 17, which is local 1 of the new window. `saveDataNpc` carries the old nPC and `saveIdxNpc` = 18, which is local 2.
- R7: On a commit, `newPs` equals the old `curS`, and `newS` is 1.
- R8: On a commit, `newTbr` is {curTbrBase[31:12], trapType[7:0], 4'b0000}.
- R9: On a commit, `newPc` equals `newTbr`, and `newNpc` equals `newTbr` + 4.
- R10: Take a committed trap whose `trapType[7:4]` = 4'h1, which is the range 0x10 to 0x1F. For it, `ackValid` is 1 in the commit cycle and `ackLevel` = `trapType[3:0]`. Every other trap type, including 0x80 and above, leaves `ackValid` at 0.
- R11: In error state, requests are ignored. `commitValid` stays 0, the new-state outputs keep their values and `errorState` stays 1 until reset.
- R12: In a cycle after which no trap was taken, `commitValid`, `saveEn` and `ackValid` are 0, and the new-state outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapReq | input | 1 | Trap request, sampled each edge |
| trapType | input | 8 | Trap number |
| shutdownEn | input | 1 | Enables shutdown on trap 0x80 when traps are disabled |
| curPc | input | 32 | Current PC |
| curNpc | input | 32 | Current next PC |
| curCwp | input | CW | Current window pointer |
| curS | input | 1 | Current supervisor bit |
| curEt | input | 1 | Current trap-enable bit |
| curTbrBase | input | 20 | Trap base address, bits 31:12 |
| commitValid | output | 1 | One-cycle strobe: new state valid |
| newPc | output | 32 | New PC |
| newNpc | output | 32 | New next PC |
| newCwp | output | CW | New window pointer |
| newPs | output | 1 | New previous-supervisor bit |
| newS | output | 1 | New supervisor bit |
| newEt | output | 1 | New trap-enable bit |
| newTbr | output | 32 | New trap base register |
| saveEn | output | 1 | Register-file write strobe for both saves |
| saveCwp | output | CW | Window the saves target |
| saveIdxPc | output | 5 | Register index for the saved PC |
| saveDataPc | output | 32 | Saved PC |
| saveIdxNpc | output | 5 | Register index for the saved nPC |
| saveDataNpc | output | 32 | Saved nPC |
| ackValid | output | 1 | Interrupt acknowledge strobe |
| ackLevel | output | 4 | Acknowledged interrupt level |
| errorState | output | 1 | Sticky error state |
| shutdownReq | output | 1 | One-cycle shutdown request |

## Verification
The only internal state is the error flag, and it shows directly on `errorState` one cycle after the offending request. A flag that sets wrongly shows as a missing `commitValid` on the next legal trap. A flag that fails to stick shows as a commit that should not happen. A wrong wrap in the window arithmetic, a wrong trap-type shift or a wrong acknowledge decode appears in the first commit cycle after the request. The vectors therefore include window 0, trap types at both ends of the interrupt range and at 0x80.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  localparam int TT_W = 8;
  localparam int ADDR_W = 32;
  localparam int BASE_LSB = 12;
  localparam int BASE_W = ADDR_W - BASE_LSB;
  localparam int IDX_W = 5;
  localparam logic [3:0] IRQ_HI = 4'h1;
  localparam logic [TT_W-1:0] SHUT_TT = 8'h80;
  localparam logic [IDX_W-1:0] IDX_SAVE_PC = 5'd17;
  localparam logic [IDX_W-1:0] IDX_SAVE_NPC = 5'd18;

  typedef struct packed {
    logic take;
    logic toError;
    logic toShutdown;
    logic ack;
  } trap_strb_t;
endpackage

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            trapReq,
  input  logic [TT_W-1:0] trapType,
  input  logic            curEt,
  input  logic            shutdownEn,
  output trap_strb_t      strb,
  output logic            errorState,
  output logic            shutdownReq
);
  logic live;
  logic isShut;

  always_comb begin
    live            = trapReq && !errorState;
    isShut          = shutdownEn && (trapType == SHUT_TT);
    strb.take       = live && curEt;
    strb.toShutdown = live && !curEt && isShut;
    strb.toError    = live && !curEt && !isShut;
    strb.ack        = live && curEt && (trapType[TT_W-1:4] == IRQ_HI);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errorState  <= 1'b0;
      shutdownReq <= 1'b0;
    end else begin
      if (strb.toError) errorState <= 1'b1;
      shutdownReq <= strb.toShutdown;
    end
  end

  assert_one_action_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.take, strb.toError, strb.toShutdown}));

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    errorState |=> errorState);

  assert_shut_no_err_R3: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> !errorState);
endmodule

// File: rtl/trap_entry_dp.sv
module trap_entry_dp
  import trap_entry_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  trap_strb_t        strb,
  input  logic [TT_W-1:0]   trapType,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] curNpc,
  input  logic [CW-1:0]     curCwp,
  input  logic              curS,
  input  logic [BASE_W-1:0] curTbrBase,
  output logic              commitValid,
  output logic [ADDR_W-1:0] newPc,
  output logic [ADDR_W-1:0] newNpc,
  output logic [CW-1:0]     newCwp,
  output logic              newPs,
  output logic              newS,
  output logic              newEt,
  output logic [ADDR_W-1:0] newTbr,
  output logic              saveEn,
  output logic [CW-1:0]     saveCwp,
  output logic [IDX_W-1:0]  saveIdxPc,
  output logic [ADDR_W-1:0] saveDataPc,
  output logic [IDX_W-1:0]  saveIdxNpc,
  output logic [ADDR_W-1:0] saveDataNpc,
  output logic              ackValid,
  output logic [3:0]        ackLevel
);
  localparam logic [CW-1:0] TOP_WIN = CW'(NWIN - 1);

  logic [CW-1:0]     cwpDec;
  logic [ADDR_W-1:0] vecAddr;

  always_comb begin
    cwpDec  = (curCwp == '0) ? TOP_WIN : curCwp - 1'b1;
    vecAddr = {curTbrBase, trapType, 4'b0000};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      commitValid <= 1'b0;
      newPc       <= '0;
      newNpc      <= '0;
      newCwp      <= '0;
      newPs       <= 1'b0;
      newS        <= 1'b0;
      newEt       <= 1'b0;
      newTbr      <= '0;
      saveEn      <= 1'b0;
      saveCwp     <= '0;
      saveIdxPc   <= '0;
      saveDataPc  <= '0;
      saveIdxNpc  <= '0;
      saveDataNpc <= '0;
      ackValid    <= 1'b0;
      ackLevel    <= '0;
    end else begin
      commitValid <= strb.take;
      saveEn      <= strb.take;
      ackValid    <= strb.ack;
      if (strb.take) begin
        newPc       <= vecAddr;
        newNpc      <= vecAddr + ADDR_W'(4);
        newTbr      <= vecAddr;
        newCwp      <= cwpDec;
        saveCwp     <= cwpDec;
        newPs       <= curS;
        newS        <= 1'b1;
        newEt       <= 1'b0;
        saveIdxPc   <= IDX_SAVE_PC;
        saveDataPc  <= curPc;
        saveIdxNpc  <= IDX_SAVE_NPC;
        saveDataNpc <= curNpc;
      end
      if (strb.ack) ackLevel <= trapType[3:0];
    end
  end

  assert_cwp_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.take && curCwp == '0) |=> (newCwp == TOP_WIN));

  assert_npc_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> (newNpc == newPc + ADDR_W'(4)));

  assert_ack_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> (commitValid && newTbr[11:8] == IRQ_HI));

  assert_s_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> (newS && !newEt));
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_entry_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trapReq,
  input  logic [TT_W-1:0]   trapType,
  input  logic              shutdownEn,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] curNpc,
  input  logic [CW-1:0]     curCwp,
  input  logic              curS,
  input  logic              curEt,
  input  logic [BASE_W-1:0] curTbrBase,
  output logic              commitValid,
  output logic [ADDR_W-1:0] newPc,
  output logic [ADDR_W-1:0] newNpc,
  output logic [CW-1:0]     newCwp,
  output logic              newPs,
  output logic              newS,
  output logic              newEt,
  output logic [ADDR_W-1:0] newTbr,
  output logic              saveEn,
  output logic [CW-1:0]     saveCwp,
  output logic [IDX_W-1:0]  saveIdxPc,
  output logic [ADDR_W-1:0] saveDataPc,
  output logic [IDX_W-1:0]  saveIdxNpc,
  output logic [ADDR_W-1:0] saveDataNpc,
  output logic              ackValid,
  output logic [3:0]        ackLevel,
  output logic              errorState,
  output logic              shutdownReq
);
  trap_strb_t strb;

  trap_entry_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapType(trapType),
    .curEt(curEt), .shutdownEn(shutdownEn), .strb(strb),
    .errorState(errorState), .shutdownReq(shutdownReq)
  );

  trap_entry_dp #(.NWIN(NWIN)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .trapType(trapType),
    .curPc(curPc), .curNpc(curNpc), .curCwp(curCwp), .curS(curS),
    .curTbrBase(curTbrBase), .commitValid(commitValid), .newPc(newPc),
    .newNpc(newNpc), .newCwp(newCwp), .newPs(newPs), .newS(newS),
    .newEt(newEt), .newTbr(newTbr), .saveEn(saveEn), .saveCwp(saveCwp),
    .saveIdxPc(saveIdxPc), .saveDataPc(saveDataPc), .saveIdxNpc(saveIdxNpc),
    .saveDataNpc(saveDataNpc), .ackValid(ackValid), .ackLevel(ackLevel)
  );
endmodule

// File: tb/sim_trap_entry_seq.sv
module sim_trap_entry_seq;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, trapReq, shutdownEn, curS, curEt;
  logic [7:0]  trapType;
  logic [31:0] curPc, curNpc;
  logic [2:0]  curCwp;
  logic [19:0] curTbrBase;
  logic        commitValid, newPs, newS, newEt, saveEn, ackValid, errorState, shutdownReq;
  logic [31:0] newPc, newNpc, newTbr, saveDataPc, saveDataNpc;
  logic [2:0]  newCwp, saveCwp;
  logic [4:0]  saveIdxPc, saveIdxNpc;
  logic [3:0]  ackLevel;

  trap_entry_seq #(.NWIN(8)) u0 (.*);

  typedef struct packed {
    logic [7:0]  tt;
    logic [31:0] pc;
    logic [2:0]  cwp;
    logic        s;
    logic [2:0]  expCwp;
    logic        expAck;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{8'h11, 32'h0000_1000, 3'd3, 1'b0, 3'd2, 1'b1},
    '{8'h1F, 32'h4000_0020, 3'd0, 1'b1, 3'd7, 1'b1},
    '{8'h10, 32'h8000_0104, 3'd7, 1'b0, 3'd6, 1'b1},
    '{8'h20, 32'h1234_5678, 3'd1, 1'b1, 3'd0, 1'b0},
    '{8'h80, 32'hFFFF_FFF0, 3'd5, 1'b0, 3'd4, 1'b0},
    '{8'h0F, 32'h0000_0040, 3'd0, 1'b1, 3'd7, 1'b0},
    '{8'h02, 32'h00C0_FFEE, 3'd2, 1'b0, 3'd1, 1'b0}
  };
  localparam logic [19:0] BASE = 20'hABCDE;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] tt, input logic [31:0] pc, input logic [2:0] cwp,
                       input logic s, input logic et, input logic shEn);
    @(negedge clk);
    trapType = tt; curPc = pc; curNpc = pc + 32'd4; curCwp = cwp;
    curS = s; curEt = et; shutdownEn = shEn; curTbrBase = BASE; trapReq = 1'b1;
    @(negedge clk);
    trapReq = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R12: watchdog expired, actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] expTbr;
    logic [31:0] heldPc;
    trapReq = 0; trapType = 0; shutdownEn = 0; curPc = 0; curNpc = 0;
    curCwp = 0; curS = 0; curEt = 0; curTbrBase = 0;
    doReset();
    @(negedge clk);
    // R1 reset state
    chk(commitValid == 0 && saveEn == 0 && ackValid == 0, "R1 strobes", {29'd0, commitValid, saveEn, ackValid}, 0);
    chk(errorState == 0 && shutdownReq == 0, "R1 error/shutdown", {30'd0, errorState, shutdownReq}, 0);
    chk(newPc == 0 && newTbr == 0 && newCwp == 0, "R1 state", newPc, 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].tt, VEC[i].pc, VEC[i].cwp, VEC[i].s, 1'b1, 1'b0);
      expTbr = {BASE, VEC[i].tt, 4'h0};
      chk(commitValid && saveEn, "R4 commit strobe", {30'd0, commitValid, saveEn}, 3);
      chk(newEt == 0, "R4 et cleared", newEt, 0);
      chk(newCwp == VEC[i].expCwp && saveCwp == VEC[i].expCwp, "R5 cwp", newCwp, VEC[i].expCwp);
      chk(saveDataPc == VEC[i].pc && saveIdxPc == 5'd17, "R6 save pc", saveDataPc, VEC[i].pc);
      chk(saveDataNpc == VEC[i].pc + 4 && saveIdxNpc == 5'd18, "R6 save npc", saveDataNpc, VEC[i].pc + 4);
      chk(newPs == VEC[i].s && newS == 1, "R7 ps/s", {30'd0, newPs, newS}, {30'd0, VEC[i].s, 1'b1});
      chk(newTbr == expTbr, "R8 tbr", newTbr, expTbr);
      chk(newPc == expTbr && newNpc == expTbr + 4, "R9 pc/npc", newNpc, expTbr + 4);
      chk(ackValid == VEC[i].expAck, "R10 ack", ackValid, VEC[i].expAck);
      if (VEC[i].expAck) chk(ackLevel == VEC[i].tt[3:0], "R10 level", ackLevel, VEC[i].tt[3:0]);
      @(negedge clk);
      chk(!commitValid && !saveEn && !ackValid, "R12 pulses end", {29'd0, commitValid, saveEn, ackValid}, 0);
      chk(newPc == expTbr && newCwp == VEC[i].expCwp, "R12 hold", newPc, expTbr);
    end
    heldPc = {BASE, 8'h02, 4'h0};

    // R3 shutdown
    drive(8'h80, 32'h100, 3'd4, 1'b1, 1'b0, 1'b1);
    chk(shutdownReq && !errorState && !commitValid, "R3 shutdown", {29'd0, shutdownReq, errorState, commitValid}, 4);
    @(negedge clk);
    chk(!shutdownReq && !errorState, "R3 pulse end", {30'd0, shutdownReq, errorState}, 0);
    chk(newPc == heldPc, "R3 no commit", newPc, heldPc);

    // R2 error entry: 0x80 with shutdown disabled
    drive(8'h80, 32'h200, 3'd4, 1'b1, 1'b0, 1'b0);
    chk(errorState && !commitValid && !shutdownReq, "R2 error", {29'd0, errorState, commitValid, shutdownReq}, 4);
    chk(newPc == heldPc, "R2 no commit", newPc, heldPc);

    // R11 ignored while in error state
    drive(8'h13, 32'h300, 3'd2, 1'b0, 1'b1, 1'b0);
    chk(!commitValid && !ackValid, "R11 ignored", {30'd0, commitValid, ackValid}, 0);
    chk(newPc == heldPc && newCwp == 3'd1, "R11 hold", newPc, heldPc);
    repeat (3) @(negedge clk);
    chk(errorState == 1, "R11 sticky", errorState, 1);

    // reset clears error; R2 with an ordinary trap type
    doReset();
    @(negedge clk);
    chk(errorState == 0 && newPc == 0, "R1 reset clears", {31'd0, errorState}, 0);
    drive(8'h05, 32'h400, 3'd6, 1'b0, 1'b0, 1'b1);
    chk(errorState && !commitValid && !shutdownReq, "R2 plain type", {29'd0, errorState, commitValid, shutdownReq}, 4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule